// File: doc/BRIEF.md
# Thermal Stage Alarm Controller

This block turns a digital die temperature, given in millidegrees Celsius, into a two-bit alarm stage from 0 to 3. It compares the temperature against three trip points. A two-bit threshold code picks the three as a set. The lowest trip point sits at 105000 mC plus 5000 mC per code step, and each further trip point lies 20000 mC above the one below it. The stage rises at once when a trip point is reached. It falls only after the temperature has dropped a hysteresis margin below the trip point it had crossed. Every change of stage produces a one-cycle interrupt pulse.

Software controls and observes the block through a small byte-wide register port. The port has an address, write data, read data and separate read and write strobes. Two read-only registers identify the block. A status register shows the current stage. A threshold register selects the trip set. An arm register carries a force-enable bit, and the comparison logic only runs while that bit is set. Sensing, conversion and any shutdown action lie outside the block.

Top module: `thermal_stage_alarm`

## Requirements
- R1: A read strobe captures the addressed register into the read data port at the next clock edge, and the read data holds while no read strobe is given. Offset 0x04 reads 0x09 and offset 0x05 reads 0x08.
- R2: Offset 0x40 holds the threshold code in bits [1:0]. It resets to 0, and its other bits read as 0.
- R3: Offset 0x46 holds the force-enable in bit 7. It resets to 0, and its other bits read as 0.
- R4: Offset 0x08 returns the current stage in bits [1:0], and its upper bits read as 0. The stage is 0 after reset.
- R5: With code c, trip point k (k = 0, 1, 2) lies at 105000 + 5000*c + 20000*k mC. At the clock edge after a temperature is presented, a rising stage becomes the number of trip points the temperature is at or above.
- R6: The stage drops below a level only when the temperature is below that level's trip point minus 2000 mC. Inside this band the stage holds.
- R7: While force-enable is set, each change of the stage gives exactly one single-cycle interrupt pulse, starting one cycle after the stage changes.
- R8: While force-enable is clear, the stage is held at 0 and no interrupt pulse is produced. Clearing force-enable at a non-zero stage drops the stage to 0 without a pulse.
- R9: Reads of offsets that map to no register return 0x00. Writes to the read-only offsets 0x04, 0x05 and 0x08 change nothing.
- R10: Writing a new threshold code moves all three trip points. The stage is re-evaluated against the new set from the next cycle, with the same hysteresis rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_mc | input | TEMP_W (18) | Die temperature in mC, unsigned |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Single-cycle stage-change pulse |

## Verification
The bench builds the block with its default parameters. These give an 18-bit temperature, three trip points, a 105000 mC base, 5000 mC and 20000 mC steps and a 2000 mC margin. With these values every one of the four threshold codes can be driven to the exact value of its lowest and highest trip point and to one below it. The edges of the hysteresis band can be hit to the millidegree: the band edge itself holds the stage and one below it drops the stage. The same settings also allow a jump over several stages at once, and a code change that moves the stage without any change in temperature.

// File: rtl/tsa_pkg.sv
// Package: register offsets, identification values and field positions
// shared by the thermal stage alarm modules.
package tsa_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] OFS_KIND    = 8'h04;
    localparam logic [REG_AW-1:0] OFS_VARIANT = 8'h05;
    localparam logic [REG_AW-1:0] OFS_STAGE   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_LIMITS  = 8'h40;
    localparam logic [REG_AW-1:0] OFS_ARM     = 8'h46;

    localparam logic [REG_DW-1:0] KIND_VAL    = 8'h09;
    localparam logic [REG_DW-1:0] VARIANT_VAL = 8'h08;

    localparam int CODE_W  = 2;
    localparam int ARM_BIT = 7;

    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/tsa_regs.sv
// Module: tsa_regs
// Register bank of the alarm. It holds the threshold code and the
// force-enable bit, and it returns registered read data.
// Assumes at most one strobe per cycle. Unmapped offsets read as zero.
module tsa_regs
    import tsa_pkg::*;
#(
    parameter int STAGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  addr_i,
    input  logic [REG_DW-1:0]  wdata_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [STAGE_W-1:0] stage_i,
    output code_t              code_o,
    output logic               arm_o,
    output logic [REG_DW-1:0]  rdata_o
);
    localparam int PAD_W = REG_DW - STAGE_W;

    logic [REG_DW-1:0] rd_mux;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata_i[REG_DW-1:ARM_BIT+1], wdata_i[ARM_BIT-1:CODE_W]};

    // Control register writes; writes to any other offset are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            arm_o  <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == OFS_LIMITS) code_o <= wdata_i[CODE_W-1:0];
            if (addr_i == OFS_ARM)    arm_o  <= wdata_i[ARM_BIT];
        end
    end

    // Read multiplexer over the register map
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            OFS_KIND:    rd_mux = KIND_VAL;
            OFS_VARIANT: rd_mux = VARIANT_VAL;
            OFS_STAGE:   rd_mux = {{PAD_W{1'b0}}, stage_i};
            OFS_LIMITS:  rd_mux = {{(REG_DW-CODE_W){1'b0}}, code_o};
            OFS_ARM:     rd_mux = {arm_o, {ARM_BIT{1'b0}}};
            default:     rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_mux;
    end

    p_kind_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == OFS_KIND) |=> (rdata_o == KIND_VAL));
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
    p_ro_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != OFS_LIMITS && addr_i != OFS_ARM) |=> ($stable(code_o) && $stable(arm_o)));
endmodule

// File: rtl/tsa_stage_eval.sv
// Module: tsa_stage_eval
// Works out the alarm stage from the temperature and the threshold code.
// The stage rises to the count of trip points reached. It falls to the
// count of trip points still within the hysteresis margin. While not armed
// it is held at zero. Assumes an unsigned temperature in millidegrees.
module tsa_stage_eval
    import tsa_pkg::*;
#(
    parameter int TEMP_W    = 18,
    parameter int NUM_TRIPS = 3,
    parameter int BASE_MC   = 105000,
    parameter int CODE_STEP = 5000,
    parameter int STAGE_STEP = 20000,
    parameter int HYST_MC   = 2000,
    localparam int STAGE_W  = $clog2(NUM_TRIPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TEMP_W-1:0]  temp_i,
    input  code_t              code_i,
    input  logic               arm_i,
    output logic [STAGE_W-1:0] stage_o
);
    localparam int CW = TEMP_W + 2;

    logic [CW-1:0]        temp_x;
    logic [CW-1:0]        temp_h;
    logic [CW-1:0]        base_trip;
    logic [NUM_TRIPS-1:0] reach;
    logic [NUM_TRIPS-1:0] keep;
    logic [STAGE_W-1:0]   reach_cnt;
    logic [STAGE_W-1:0]   keep_cnt;
    logic [STAGE_W-1:0]   stage_nxt;

    // Widen the temperature and add the margin for the falling compare
    assign temp_x    = {2'b00, temp_i};
    assign temp_h    = temp_x + CW'(HYST_MC);
    assign base_trip = CW'(BASE_MC) + CW'(code_i) * CW'(CODE_STEP);

    for (genvar k = 0; k < NUM_TRIPS; k++) begin : g_trip
        logic [CW-1:0] trip;
        assign trip     = base_trip + CW'(k * STAGE_STEP);
        assign reach[k] = (temp_x >= trip);
        assign keep[k]  = (temp_h >= trip);
    end

    assign reach_cnt = STAGE_W'($countones(reach));
    assign keep_cnt  = STAGE_W'($countones(keep));

    // Choose a rise, a fall or a hold
    always_comb begin
        stage_nxt = stage_o;
        if (!arm_i)                  stage_nxt = '0;
        else if (reach_cnt > stage_o) stage_nxt = reach_cnt;
        else if (keep_cnt < stage_o)  stage_nxt = keep_cnt;
    end

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) stage_o <= '0;
        else        stage_o <= stage_nxt;
    end

    p_disarmed_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (stage_o == '0));
    p_rise_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o > $past(stage_o)) |-> ({2'b00, $past(temp_i)} >= CW'(BASE_MC)));
    p_fall_margin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_o < $past(stage_o)) && $past(arm_i)) |-> ({2'b00, $past(temp_i)} + CW'(HYST_MC) < CW'(BASE_MC) + CW'(NUM_TRIPS - 1) * CW'(STAGE_STEP) + CW'(3) * CW'(CODE_STEP)));
endmodule

// File: rtl/tsa_irq_gen.sv
// Module: tsa_irq_gen
// Produces a one-cycle interrupt after each change of the stage while armed.
// Assumes the stage input comes from a register.
module tsa_irq_gen #(
    parameter int STAGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STAGE_W-1:0] stage_i,
    input  logic               arm_i,
    output logic               irq_o
);
    logic [STAGE_W-1:0] stage_prev;

    // Remember the last stage and flag a difference when armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_prev <= '0;
            irq_o      <= 1'b0;
        end else begin
            stage_prev <= stage_i;
            irq_o      <= arm_i && (stage_i != stage_prev);
        end
    end
endmodule

// File: rtl/thermal_stage_alarm.sv
// Module: thermal_stage_alarm
// Top of the thermal stage alarm: the register bank, the stage evaluator
// and the interrupt generator. Assumes one clock domain and a temperature
// input that is already synchronous.
module thermal_stage_alarm
    import tsa_pkg::*;
#(
    parameter int TEMP_W     = 18,
    parameter int NUM_TRIPS  = 3,
    parameter int BASE_MC    = 105000,
    parameter int CODE_STEP  = 5000,
    parameter int STAGE_STEP = 20000,
    parameter int HYST_MC    = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_mc,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    output logic              alarm_irq
);
    localparam int STAGE_W = $clog2(NUM_TRIPS + 1);

    code_t              code;
    logic               arm;
    logic [STAGE_W-1:0] stage;

    tsa_regs #(.STAGE_W(STAGE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .stage_i (stage),
        .code_o  (code),
        .arm_o   (arm),
        .rdata_o (reg_rdata)
    );

    tsa_stage_eval #(
        .TEMP_W     (TEMP_W),
        .NUM_TRIPS  (NUM_TRIPS),
        .BASE_MC    (BASE_MC),
        .CODE_STEP  (CODE_STEP),
        .STAGE_STEP (STAGE_STEP),
        .HYST_MC    (HYST_MC)
    ) u_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .temp_i  (temp_mc),
        .code_i  (code),
        .arm_i   (arm),
        .stage_o (stage)
    );

    tsa_irq_gen #(.STAGE_W(STAGE_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stage_i (stage),
        .arm_i   (arm),
        .irq_o   (alarm_irq)
    );

    p_irq_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && stage != $past(stage)) |=> alarm_irq);
    p_irq_quiet_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !$past(arm)) |=> !alarm_irq);
endmodule

// File: tb/thermal_stage_alarm_tb.sv
`timescale 1ns/1ps
module thermal_stage_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] temp_mc = '0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    thermal_stage_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .temp_mc(temp_mc),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
    );

    always @(negedge clk) if (rst_n && alarm_irq) irq_cnt++;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = int'(reg_rdata);
    endtask

    // Apply a temperature and wait until any interrupt pulse is over
    task automatic heat(int t);
        @(negedge clk);
        temp_mc = 18'(t);
        repeat (3) @(negedge clk);
    endtask

    task automatic stage_is(string req, int exp);
        int v;
        rd(8'h08, v);
        chk(req, v, exp);
    endtask

    task automatic cool_down();
        heat(0);
        wr(8'h40, 8'h00);
        heat(0);
    endtask

    task automatic t_reset();
        int v;
        chk("R7 irq low in reset", int'(alarm_irq), 0);
        rd(8'h40, v); chk("R2 limits reset", v, 0);
        rd(8'h46, v); chk("R3 arm reset", v, 0);
        rd(8'h08, v); chk("R4 stage reset", v, 0);
    endtask

    task automatic t_ident();
        int v;
        rd(8'h04, v); chk("R1 kind", v, 9);
        rd(8'h05, v); chk("R1 variant", v, 8);
        @(negedge clk); reg_addr = 8'h46;
        @(negedge clk);
        chk("R1 rdata holds without strobe", int'(reg_rdata), 8);
        wr(8'h04, 8'hFF); wr(8'h05, 8'h00); wr(8'h08, 8'h03);
        rd(8'h04, v); chk("R9 kind write ignored", v, 9);
        rd(8'h05, v); chk("R9 variant write ignored", v, 8);
        rd(8'h08, v); chk("R9 status write ignored", v, 0);
        rd(8'h40, v); chk("R9 limits untouched by ro writes", v, 0);
        rd(8'h46, v); chk("R9 arm untouched by ro writes", v, 0);
    endtask

    task automatic t_unmapped();
        int v;
        rd(8'h00, v); chk("R9 unmapped 0x00", v, 0);
        rd(8'h41, v); chk("R9 unmapped 0x41", v, 0);
        rd(8'hFF, v); chk("R9 unmapped 0xFF", v, 0);
    endtask

    task automatic t_ctrl();
        int v;
        wr(8'h40, 8'hFE); rd(8'h40, v); chk("R2 limits masks upper bits", v, 2);
        wr(8'h46, 8'h7F); rd(8'h46, v); chk("R3 arm bit7 clear", v, 0);
        wr(8'h46, 8'hFF); rd(8'h46, v); chk("R3 arm reads 0x80", v, 128);
        wr(8'h46, 8'h00);
        wr(8'h40, 8'h00);
    endtask

    task automatic t_disarmed();
        int n;
        n = irq_cnt;
        heat(170000);
        stage_is("R8 stage held 0 when disarmed", 0);
        chk("R8 no irq when disarmed", irq_cnt - n, 0);
        heat(0);
    endtask

    task automatic t_rise();
        int n;
        wr(8'h46, 8'h80);
        n = irq_cnt;
        heat(104999); stage_is("R5 below trip0", 0);
        chk("R7 no irq without change", irq_cnt - n, 0);
        heat(105000); stage_is("R5 at trip0", 1);
        chk("R7 one pulse on rise", irq_cnt - n, 1);
        heat(144999); stage_is("R5 below trip2", 2);
        heat(145000); stage_is("R5 at trip2", 3);
        chk("R7 pulses per change", irq_cnt - n, 3);
        heat(0); stage_is("R5 drop to 0", 0);
        n = irq_cnt;
        heat(200000); stage_is("R5 jump to 3", 3);
        chk("R7 one pulse on multi-stage jump", irq_cnt - n, 1);
        heat(0);
    endtask

    task automatic t_pulse_width();
        @(negedge clk); temp_mc = 18'd130000;
        @(negedge clk);
        chk("R7 irq low in change cycle", int'(alarm_irq), 0);
        @(negedge clk);
        chk("R7 irq high one cycle after change", int'(alarm_irq), 1);
        @(negedge clk);
        chk("R7 irq single cycle", int'(alarm_irq), 0);
        heat(0);
    endtask

    task automatic t_hyst();
        heat(125000); stage_is("R6 setup stage 2", 2);
        heat(123000); stage_is("R6 band edge holds", 2);
        heat(122999); stage_is("R6 below band drops", 1);
        heat(124999); stage_is("R6 no rise inside band", 1);
        heat(103000); stage_is("R6 trip0 band edge holds", 1);
        heat(102999); stage_is("R6 trip0 below band", 0);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 4; c++) begin
            int lo;
            lo = 105000 + 5000 * c;
            cool_down();
            wr(8'h40, 8'(c));
            heat(lo - 1);  stage_is($sformatf("R5 code%0d below trip0", c), 0);
            heat(lo);      stage_is($sformatf("R5 code%0d at trip0", c), 1);
            heat(lo + 40000 - 1); stage_is($sformatf("R5 code%0d below trip2", c), 2);
            heat(lo + 40000); stage_is($sformatf("R5 code%0d at trip2", c), 3);
        end
        cool_down();
    endtask

    task automatic t_code_change();
        int n;
        heat(112000); stage_is("R10 setup code0", 1);
        n = irq_cnt;
        wr(8'h40, 8'h02);
        repeat (3) @(negedge clk);
        stage_is("R10 code2 drops stage", 0);
        chk("R10 irq on code change", irq_cnt - n, 1);
        wr(8'h40, 8'h01);
        repeat (3) @(negedge clk);
        stage_is("R10 code1 raises stage", 1);
        cool_down();
    endtask

    task automatic t_disarm_drop();
        int n;
        heat(130000); stage_is("R8 armed at stage 2", 2);
        n = irq_cnt;
        wr(8'h46, 8'h00);
        repeat (3) @(negedge clk);
        stage_is("R8 disarm drops stage", 0);
        chk("R8 disarm gives no pulse", irq_cnt - n, 0);
        wr(8'h46, 8'h80);
        repeat (3) @(negedge clk);
        stage_is("R8 rearm restores stage", 2);
        chk("R7 rearm change pulses", irq_cnt - n, 1);
        heat(0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_unmapped();
        t_ctrl();
        t_disarmed();
        t_rise();
        t_pulse_width();
        t_hyst();
        t_codes();
        t_code_change();
        t_disarm_drop();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule